// File: doc/BRIEF.md
# Clearable Tag Compare Memory

This block holds one tag word per entry and answers a single question about it: does the word on the compare input equal the word stored at the addressed entry? It has no path that returns stored contents. An entry is either updated with the presented word (write mode) or compared against it (compare mode). The answer is one registered flag.

A clear input empties the whole array in one clock. A per-entry flag vector records which entries hold a written word. An entry whose flag is down compares as an all-zero word. If a system ties one bit of every compare word to 1 as a valid marker, then any entry not written since the last clear reports a miss. The default shape is 4096 entries of 12 bits, held as three 4-bit slices that share one address. Depth, width and slice width are parameters, so a 16384-entry version uses a 14-bit address.

Top module: `tag_cmp_mem`

## Requirements
- R1: After reset, `hit` is 0 and every entry compares as the all-zero word.
- R2: With `wr_en`=1 and `clr`=0, `tag_in` is stored at entry `addr`. A compare of the same word at the same address in the next cycle sets `hit`.
- R3: `hit` is registered. It shows the result for the `addr`/`tag_in` sampled at the previous rising clock edge. It updates on every cycle, including write cycles, where it reflects the contents before the write.
- R4: `hit` is 1 only when every bit of `tag_in` equals the stored word. A difference in any single bit, in any slice, gives 0.
- R5: A one-cycle `clr` pulse returns all entries to the unwritten state. From the next cycle, every entry compares as all zeros.
- R6: A compare word with its top bit (bit WIDTH-1) set to 1 never matches an entry that is unwritten or cleared.
- R7: When `clr` and `wr_en` are both 1 in one cycle, the clear takes effect and the write is discarded.
- R8: A write changes only the addressed entry. The other entries keep their previous compare results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset; acts as a clear |
| addr | input | ADDR_W ($clog2(DEPTH)) | Entry select |
| tag_in | input | WIDTH | Word to compare, or word to store |
| wr_en | input | 1 | 1 = write mode, 0 = compare mode |
| clr | input | 1 | Invalidate every entry in one cycle |
| hit | output | 1 | Registered equality result |

## Verification
The comparator is driven with exact copies of stored words, with words that differ in a single bit in the low, middle and top slices, and with the all-zero word. Together these separate a correct full-width equality from one that checks only some slices. Unwritten and cleared entries are probed with both zero and valid-marked words, so a clear that only hides entries is told apart from one that truly empties them. Writing to one address and then probing a neighbour shows whether writes leak across entries. Asserting write and clear in the same cycle shows which one takes priority.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
    localparam int DEF_DEPTH   = 4096;
    localparam int DEF_WIDTH   = 12;
    localparam int DEF_SLICE_W = 4;

    typedef struct packed {
        logic hit;
    } tcm_out_t;
endpackage

// File: rtl/tcm_flags.sv
module tcm_flags #(
    parameter int DEPTH  = 4096,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              clr,
    output logic              flag_at
);
    logic [DEPTH-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) begin
            flag_d = '0;
        end else if (wr_en) begin
            flag_d[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_at = flag_q[addr];

    a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (flag_q == '0));
    a_r2_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> flag_q[$past(addr)]);
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr) |=> !flag_q[$past(addr)]);
endmodule

// File: rtl/tcm_slice.sv
module tcm_slice #(
    parameter int DEPTH   = 4096,
    parameter int SLICE_W = 4,
    parameter int ADDR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SLICE_W-1:0] word,
    input  logic               wr_go,
    output logic               eq
);
    logic [SLICE_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go) store_q[addr] <= word;
    end

    assign eq = (store_q[addr] == word);
endmodule

// File: rtl/tag_cmp_mem.sv
module tag_cmp_mem
    import tcm_pkg::*;
#(
    parameter int DEPTH   = DEF_DEPTH,
    parameter int WIDTH   = DEF_WIDTH,
    parameter int SLICE_W = DEF_SLICE_W,
    parameter int ADDR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  tag_in,
    input  logic              wr_en,
    input  logic              clr,
    output logic              hit
);
    localparam int NSLICE = WIDTH / SLICE_W;

    tcm_out_t   st_d, st_q;
    logic       flag_at;
    logic       wr_go;
    logic [NSLICE-1:0] slice_eq;

    assign wr_go = wr_en && !clr;

    tcm_flags #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .clr     (clr),
        .flag_at (flag_at)
    );

    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        tcm_slice #(.DEPTH(DEPTH), .SLICE_W(SLICE_W), .ADDR_W(ADDR_W)) i_slice (
            .clk   (clk),
            .addr  (addr),
            .word  (tag_in[s*SLICE_W +: SLICE_W]),
            .wr_go (wr_go),
            .eq    (slice_eq[s])
        );
    end

    always_comb begin
        st_d = st_q;
        if (flag_at) st_d.hit = &slice_eq;
        else         st_d.hit = (tag_in == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = st_q.hit;

    a_r6_cleared_miss: assert property (@(posedge clk) disable iff (!rst_n)
        clr ##1 (tag_in[WIDTH-1]) |=> !hit);
    a_r2_write_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go ##1 (addr == $past(addr) && tag_in == $past(tag_in)) |=> hit);
    a_r5_cleared_zero_hit: assert property (@(posedge clk) disable iff (!rst_n)
        clr ##1 (tag_in == '0) |=> hit);
endmodule

// File: tb/test_tag_cmp_mem.sv
module test_tag_cmp_mem;
    localparam int DEPTH  = 4096;
    localparam int WIDTH  = 12;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic [WIDTH-1:0]  tag_in;
    logic              wr_en;
    logic              clr;
    logic              hit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tag_cmp_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_tag_cmp_mem (
        .clk(clk), .rst_n(rst_n), .addr(addr), .tag_in(tag_in),
        .wr_en(wr_en), .clr(clr), .hit(hit)
    );

    task automatic chk(input logic exp, input string req);
        checks++;
        if (hit !== exp) begin
            errors++;
            $display("FAIL %s: hit=%0b expected=%0b", req, hit, exp);
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] w);
        addr = a; tag_in = w; wr_en = 1'b1; clr = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic probe(input logic [ADDR_W-1:0] a, input logic [WIDTH-1:0] w,
                         input logic exp, input string req);
        addr = a; tag_in = w; wr_en = 1'b0; clr = 1'b0;
        @(negedge clk);
        chk(exp, req);
    endtask

    task automatic do_clear();
        clr = 1'b1; wr_en = 1'b0;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(1'b0, "R1 hit low after reset");
        probe(12'h000, 12'h000, 1'b1, "R1 zero word hits unwritten entry");
        probe(12'hFFF, 12'h001, 1'b0, "R1 nonzero word misses unwritten entry");
    endtask

    task automatic t_write_compare();
        do_write(12'h123, 12'h5A7);
        probe(12'h123, 12'h5A7, 1'b1, "R2 compare after write");
        probe(12'h123, 12'h000, 1'b0, "R3 result follows new word next cycle");
        probe(12'h123, 12'h5A7, 1'b1, "R3 hit returns one cycle later");
        do_write(12'h123, 12'h3C1);
        probe(12'h123, 12'h3C1, 1'b1, "R2 overwrite visible");
        probe(12'h123, 12'h5A7, 1'b0, "R2 old word no longer hits");
    endtask

    task automatic t_bitflip();
        do_write(12'h0AB, 12'h6B9);
        for (int b = 0; b < WIDTH; b++) begin
            probe(12'h0AB, 12'h6B9 ^ (12'h1 << b), 1'b0, $sformatf("R4 bit %0d differs", b));
        end
        probe(12'h0AB, 12'h6B9, 1'b1, "R4 exact word hits");
    endtask

    task automatic t_isolation();
        do_write(12'h200, 12'h777);
        probe(12'h201, 12'h777, 1'b0, "R8 neighbour not written");
        probe(12'h201, 12'h000, 1'b1, "R8 neighbour still unwritten");
        probe(12'h123, 12'h3C1, 1'b1, "R8 earlier entry kept");
    endtask

    task automatic t_valid_bit();
        probe(12'h345, 12'h800, 1'b0, "R6 marked word misses unwritten");
        do_write(12'h345, 12'h812);
        probe(12'h345, 12'h812, 1'b1, "R6 marked word hits after write");
    endtask

    task automatic t_clear();
        do_clear();
        probe(12'h345, 12'h812, 1'b0, "R5 cleared entry misses");
        probe(12'h123, 12'h3C1, 1'b0, "R5 second cleared entry misses");
        probe(12'h0AB, 12'h000, 1'b1, "R5 cleared entry reads as zero");
        probe(12'h200, 12'h800, 1'b0, "R6 marked word misses cleared entry");
    endtask

    task automatic t_clear_vs_write();
        addr = 12'h456; tag_in = 12'h9E5; wr_en = 1'b1; clr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; clr = 1'b0;
        probe(12'h456, 12'h9E5, 1'b0, "R7 write dropped under clear");
        probe(12'h456, 12'h000, 1'b1, "R7 entry left clear");
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; tag_in = '0; wr_en = 1'b0; clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_compare();
        t_bitflip();
        t_isolation();
        t_valid_bit();
        t_clear();
        t_clear_vs_write();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule